// File: doc/BRIEF.md
# Two-Wide Reorder Buffer with In-Order Retirement

This block keeps in-flight instructions in program order in a circular buffer. Rename logic allocates up to two entries per cycle at the tail. For each entry it supplies the destination logical register and the physical register that the destination mapped to before renaming. Execution units report results by entry index on two writeback ports. The buffer marks those entries as complete and retires them from the head, at most two per cycle.

Retirement is strictly in order. An entry retires only when every older entry has retired earlier or retires in the same cycle. A second entry retires only beside the head entry, and only when both completions were recorded in an earlier cycle. Each retiring entry drives its logical register and its old physical register onto a release lane for exactly one cycle, so a free list can reclaim the stale physical register.

Top module: `rob_top`

## Requirements
- R1: After reset the buffer is empty. `allocReady` is 1, `allocIdx0` is 0, `allocIdx1` is 1 and `commitValid` is 2'b00.
- R2: An accepted allocation writes lane 0 at index `allocIdx0` (the tail) and lane 1 at `allocIdx1` (tail+1 modulo depth). Lane 1 is accepted only together with lane 0; `allocValid` = 2'b10 allocates nothing. The tail advances by the number of accepted lanes.
- R3: `allocReady` is 1 exactly when at least two slots are free. While it is 0, `allocValid` is ignored and the tail does not move.
- R4: A writeback reported at a clock edge makes that entry eligible to retire from the next cycle on, never in the cycle the writeback is presented.
- R5: If the head entry is not complete, nothing retires that cycle, even when the entry behind it is complete.
- R6: `commitValid[0]` is 1 when the buffer is non-empty and its head is complete. `commitValid[1]` is 1 only when `commitValid[0]` is 1 and the next entry is also allocated and complete. The head then advances by the number retired.
- R7: Each retiring lane presents the logical register and old physical register that were given at allocation for that entry: lane 0 for the head, lane 1 for the entry after it.
- R8: Indices wrap modulo the depth (16). A completely full buffer and an empty one are told apart, so a full buffer never accepts more entries and an empty one never retires.
- R9: Every allocated entry retires exactly once, in allocation order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| allocValid | input | 2 | Allocation request per lane; bit 0 is the older instruction |
| allocLreg0 | input | 4 | Destination logical register, lane 0 |
| allocOldPreg0 | input | 6 | Previous physical mapping, lane 0 |
| allocLreg1 | input | 4 | Destination logical register, lane 1 |
| allocOldPreg1 | input | 6 | Previous physical mapping, lane 1 |
| allocReady | output | 1 | At least two free slots this cycle |
| allocIdx0 | output | 4 | Index given to lane 0 (tail) |
| allocIdx1 | output | 4 | Index given to lane 1 (tail+1) |
| wbValid | input | 2 | Writeback-complete strobe per port |
| wbIdx0 | input | 4 | Entry index completed on port 0 |
| wbIdx1 | input | 4 | Entry index completed on port 1 |
| commitValid | output | 2 | Retire strobe per lane; bit 0 is the head |
| commitLreg0 | output | 4 | Logical register retiring on lane 0 |
| commitOldPreg0 | output | 6 | Physical register released on lane 0 |
| commitLreg1 | output | 4 | Logical register retiring on lane 1 |
| commitOldPreg1 | output | 6 | Physical register released on lane 1 |

## Verification
A corrupted head pointer or completion flag shows up at the release lanes in the very next cycle. The wrong payload appears there, or a retirement happens early or never happens, and the bench compares both against an in-order queue of what was allocated. A tail pointer that drifts shows within one cycle on `allocIdx0`/`allocIdx1` and `allocReady`, which the bench predicts from its own occupancy count. A full/empty confusion shows as soon as the buffer fills or drains, because `allocReady` or `commitValid` then disagrees with the expected count. Random writeback order over several thousand cycles drives the pointers around the ring many times, so wrap faults surface within 16 allocations.

// File: rtl/rob_pkg.sv
package rob_pkg;
  localparam int ROB_DEPTH = 16;
  localparam int LREG_W    = 4;
  localparam int PREG_W    = 6;
  localparam int LANES     = 2;
  localparam int WB_PORTS  = 2;
  localparam int IDX_W     = $clog2(ROB_DEPTH);
  localparam int PTR_W     = IDX_W + 1;

  typedef logic [IDX_W-1:0] robIdx_t;
  typedef logic [PTR_W-1:0] robPtr_t;

  // strobes from control to the entry storage
  typedef struct packed {
    logic [LANES-1:0] allocEn;
    logic [LANES-1:0] commitEn;
    robIdx_t          tailIdx;
    robIdx_t          headIdx;
  } robStrobe_t;
endpackage

// File: rtl/rob_ctrl.sv
module rob_ctrl
  import rob_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [LANES-1:0] allocReq,
  input  logic [LANES-1:0] headDone,
  output robStrobe_t       strb,
  output logic             allocReady,
  output robPtr_t          headPtr,
  output robPtr_t          tailPtr
);
  robPtr_t          occupancy;
  logic [PTR_W:0]   freeSlots;
  logic [LANES-1:0] allocEn;
  logic [LANES-1:0] commitEn;
  robPtr_t          nAlloc;
  robPtr_t          nCommit;

  // the extra pointer bit keeps full (difference = depth) apart from empty
  assign occupancy  = tailPtr - headPtr;
  assign freeSlots  = (PTR_W+1)'(ROB_DEPTH) - {1'b0, occupancy};
  assign allocReady = freeSlots >= (PTR_W+1)'(LANES);

  always_comb begin
    nAlloc  = '0;
    nCommit = '0;
    for (int l = 0; l < LANES; l++) begin
      // each lane depends on the older lane: contiguous groups only
      if (l == 0) begin
        allocEn[l]  = allocReady & allocReq[l];
        commitEn[l] = (occupancy > PTR_W'(l)) & headDone[l];
      end else begin
        allocEn[l]  = allocEn[l-1] & allocReq[l];
        commitEn[l] = commitEn[l-1] & (occupancy > PTR_W'(l)) & headDone[l];
      end
      nAlloc  = nAlloc + PTR_W'(allocEn[l]);
      nCommit = nCommit + PTR_W'(commitEn[l]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headPtr <= '0;
      tailPtr <= '0;
    end else begin
      headPtr <= headPtr + nCommit;
      tailPtr <= tailPtr + nAlloc;
    end
  end

  assign strb.allocEn  = allocEn;
  assign strb.commitEn = commitEn;
  assign strb.tailIdx  = tailPtr[IDX_W-1:0];
  assign strb.headIdx  = headPtr[IDX_W-1:0];
endmodule

// File: rtl/rob_data.sv
module rob_data
  import rob_pkg::*;
(
  input  logic                             clk,
  input  logic                             rstN,
  input  robStrobe_t                       strb,
  input  logic [LANES-1:0][LREG_W-1:0]     allocLreg,
  input  logic [LANES-1:0][PREG_W-1:0]     allocPreg,
  input  logic [WB_PORTS-1:0]              wbValid,
  input  logic [WB_PORTS-1:0][IDX_W-1:0]   wbIdx,
  output logic [LANES-1:0]                 headDone,
  output logic [LANES-1:0][LREG_W-1:0]     headLreg,
  output logic [LANES-1:0][PREG_W-1:0]     headPreg
);
  logic [LREG_W-1:0]    lregMem [ROB_DEPTH];
  logic [PREG_W-1:0]    pregMem [ROB_DEPTH];
  logic [ROB_DEPTH-1:0] doneVec;

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (strb.allocEn[l]) begin
        lregMem[robIdx_t'(strb.tailIdx + IDX_W'(l))] <= allocLreg[l];
        pregMem[robIdx_t'(strb.tailIdx + IDX_W'(l))] <= allocPreg[l];
      end
    end
  end

  // completion flags: retire and allocate clear, writeback sets
  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneVec <= '0;
    end else begin
      for (int l = 0; l < LANES; l++) begin
        if (strb.commitEn[l]) doneVec[robIdx_t'(strb.headIdx + IDX_W'(l))] <= 1'b0;
        if (strb.allocEn[l])  doneVec[robIdx_t'(strb.tailIdx + IDX_W'(l))] <= 1'b0;
      end
      for (int p = 0; p < WB_PORTS; p++) begin
        if (wbValid[p]) doneVec[wbIdx[p]] <= 1'b1;
      end
    end
  end

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      headDone[l] = doneVec[robIdx_t'(strb.headIdx + IDX_W'(l))];
      headLreg[l] = lregMem[robIdx_t'(strb.headIdx + IDX_W'(l))];
      headPreg[l] = pregMem[robIdx_t'(strb.headIdx + IDX_W'(l))];
    end
  end
endmodule

// File: rtl/rob_top.sv
module rob_top
  import rob_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        allocValid,
  input  logic [LREG_W-1:0] allocLreg0,
  input  logic [PREG_W-1:0] allocOldPreg0,
  input  logic [LREG_W-1:0] allocLreg1,
  input  logic [PREG_W-1:0] allocOldPreg1,
  output logic              allocReady,
  output logic [IDX_W-1:0]  allocIdx0,
  output logic [IDX_W-1:0]  allocIdx1,
  input  logic [1:0]        wbValid,
  input  logic [IDX_W-1:0]  wbIdx0,
  input  logic [IDX_W-1:0]  wbIdx1,
  output logic [1:0]        commitValid,
  output logic [LREG_W-1:0] commitLreg0,
  output logic [PREG_W-1:0] commitOldPreg0,
  output logic [LREG_W-1:0] commitLreg1,
  output logic [PREG_W-1:0] commitOldPreg1
);
  robStrobe_t                    strb;
  robPtr_t                       headPtr;
  robPtr_t                       tailPtr;
  logic [LANES-1:0]              headDone;
  logic [LANES-1:0][LREG_W-1:0]  headLreg;
  logic [LANES-1:0][PREG_W-1:0]  headPreg;

  rob_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .allocReq   (allocValid),
    .headDone   (headDone),
    .strb       (strb),
    .allocReady (allocReady),
    .headPtr    (headPtr),
    .tailPtr    (tailPtr)
  );

  rob_data i_data (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .allocLreg ({allocLreg1, allocLreg0}),
    .allocPreg ({allocOldPreg1, allocOldPreg0}),
    .wbValid   (wbValid),
    .wbIdx     ({wbIdx1, wbIdx0}),
    .headDone  (headDone),
    .headLreg  (headLreg),
    .headPreg  (headPreg)
  );

  assign allocIdx0      = strb.tailIdx;
  assign allocIdx1      = strb.tailIdx + IDX_W'(1);
  assign commitValid    = strb.commitEn;
  assign commitLreg0    = headLreg[0];
  assign commitOldPreg0 = headPreg[0];
  assign commitLreg1    = headLreg[1];
  assign commitOldPreg1 = headPreg[1];
endmodule

// File: rtl/rob_chk.sv
module rob_chk
  import rob_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             allocReady,
  input logic             allocLane0,
  input logic [1:0]       commitValid,
  input logic             wbValid0,
  input logic [IDX_W-1:0] wbIdx0,
  input robPtr_t          headPtr,
  input robPtr_t          tailPtr
);
  // R6
  lane1_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    commitValid[1] |-> commitValid[0]);

  // R4
  wb_not_same_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wbValid0 && wbIdx0 == headPtr[IDX_W-1:0] && tailPtr != headPtr) |-> !commitValid[0]);

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    !allocReady |=> $stable(tailPtr));

  // R8
  occupancy_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    robPtr_t'(tailPtr - headPtr) <= PTR_W'(ROB_DEPTH));

  // R2
  tail_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    (allocReady && allocLane0) |=> tailPtr != $past(tailPtr));
endmodule

bind rob_top rob_chk i_chk (
  .clk         (clk),
  .rstN        (rstN),
  .allocReady  (allocReady),
  .allocLane0  (allocValid[0]),
  .commitValid (commitValid),
  .wbValid0    (wbValid[0]),
  .wbIdx0      (wbIdx0),
  .headPtr     (headPtr),
  .tailPtr     (tailPtr)
);

// File: tb/test_rob_top.sv
module test_rob_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] allocValid = '0;
  logic [3:0] allocLreg0 = '0, allocLreg1 = '0;
  logic [5:0] allocOldPreg0 = '0, allocOldPreg1 = '0;
  logic       allocReady;
  logic [3:0] allocIdx0, allocIdx1;
  logic [1:0] wbValid = '0;
  logic [3:0] wbIdx0 = '0, wbIdx1 = '0;
  logic [1:0] commitValid;
  logic [3:0] commitLreg0, commitLreg1;
  logic [5:0] commitOldPreg0, commitOldPreg1;

  int vectors = 0;
  int miscompares = 0;

  // reference model state
  int   mHead = 0;
  int   mCount = 0;
  bit   mDone [DEPTH];
  int   seq = 0;
  logic [9:0] expQ [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rob_top i_rob_top (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [9:0] payload(input int n);
    return {4'(n % 16), 6'((n * 5 + 3) % 64)};
  endfunction

  // one cycle: monitor the outputs, then drive the next inputs
  task automatic tick(input logic [1:0] av, input logic [1:0] wv,
                      input int w0, input int w1, input bit rndWb, input string tag);
    int   tail;
    bit   expReady, e0, e1;
    logic [9:0] got, want;
    @(negedge clk);
    tail     = (mHead + mCount) % DEPTH;
    expReady = (DEPTH - mCount) >= 2;
    check(allocReady === expReady, "R3", int'(allocReady), int'(expReady));
    check(allocIdx0 === 4'(tail), "R2", int'(allocIdx0), tail);
    check(allocIdx1 === 4'((tail + 1) % DEPTH), "R2", int'(allocIdx1), (tail + 1) % DEPTH);
    e0 = mCount >= 1 && mDone[mHead];
    e1 = e0 && mCount >= 2 && mDone[(mHead + 1) % DEPTH];
    check(commitValid === {e1, e0}, tag, int'(commitValid), int'({e1, e0}));
    for (int l = 0; l < 2; l++) begin
      if (commitValid[l]) begin
        got = (l == 0) ? {commitLreg0, commitOldPreg0} : {commitLreg1, commitOldPreg1};
        if (expQ.size() == 0) check(1'b0, "R9", int'(got), -1);
        else begin
          want = expQ.pop_front();
          check(got === want, "R7", int'(got), int'(want));
        end
      end
    end
    if (e0) begin mDone[mHead] = 0; mHead = (mHead + 1) % DEPTH; mCount--; end
    if (e1) begin mDone[mHead] = 0; mHead = (mHead + 1) % DEPTH; mCount--; end
    allocValid    = av;
    {allocLreg0, allocOldPreg0} = payload(seq);
    {allocLreg1, allocOldPreg1} = payload(seq + 1);
    if (expReady && av[0]) begin
      expQ.push_back(payload(seq)); mDone[tail] = 0; mCount++; seq++;
      if (av[1]) begin
        expQ.push_back(payload(seq)); mDone[(tail + 1) % DEPTH] = 0; mCount++; seq++;
      end
    end
    if (rndWb) begin
      wv = '0;
      for (int p = 0; p < 2; p++) begin
        int cand;
        if (mCount > 0) begin
          cand = (mHead + int'($urandom % 32'(mCount))) % DEPTH;
          if (!mDone[cand]) begin
            // entries allocated this cycle are not yet eligible targets
            if (((cand - mHead + DEPTH) % DEPTH) < mCount - 2 || !(expReady && av[0])) begin
              if (p == 0) begin w0 = cand; wv[0] = 1'b1; mDone[cand] = 1; end
              else begin w1 = cand; wv[1] = 1'b1; mDone[cand] = 1; end
            end
          end
        end
      end
    end else begin
      if (wv[0]) mDone[w0] = 1;
      if (wv[1]) mDone[w1] = 1;
    end
    wbValid = wv;
    wbIdx0  = 4'(w0);
    wbIdx1  = 4'(w1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    miscompares++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(allocReady === 1'b1, "R1", int'(allocReady), 1);
    check(allocIdx0 === 4'd0, "R1", int'(allocIdx0), 0);
    check(allocIdx1 === 4'd1, "R1", int'(allocIdx1), 1);
    check(commitValid === 2'b00, "R1", int'(commitValid), 0);
    rstN = 1'b1;

    tick(2'b11, 2'b00, 0, 0, 0, "R1");
    tick(2'b11, 2'b00, 0, 0, 0, "R6");
    tick(2'b10, 2'b01, 1, 0, 0, "R6");   // lane 1 alone: R2 no allocation
    tick(2'b00, 2'b00, 0, 0, 0, "R5");   // entry 1 done, head not: R5
    tick(2'b00, 2'b01, 0, 0, 0, "R5");   // writeback head
    tick(2'b00, 2'b00, 0, 0, 0, "R4");   // both retire now: R4
    tick(2'b00, 2'b11, 3, 2, 0, "R6");
    tick(2'b00, 2'b00, 0, 0, 0, "R6");

    // fill to full, then try one more allocation (R3, R8)
    for (int k = 0; k < 8; k++) tick(2'b11, 2'b00, 0, 0, 0, "R8");
    tick(2'b11, 2'b00, 0, 0, 0, "R3");
    tick(2'b01, 2'b00, 0, 0, 0, "R3");

    // complete youngest first, then drain (R5, R8)
    for (int k = 0; k < 8; k++)
      tick(2'b00, 2'b11, (mHead + 15 - 2*k) % DEPTH, (mHead + 14 - 2*k) % DEPTH, 0, "R5");
    while (mCount > 0) tick(2'b00, 2'b00, 0, 0, 0, "R8");
    tick(2'b00, 2'b00, 0, 0, 0, "R8");

    // random traffic over many wraps
    for (int k = 0; k < 3000; k++) tick(2'($urandom % 4), 2'b00, 0, 0, 1, "R6");
    for (int k = 0; k < 400 && mCount > 0; k++) tick(2'b00, 2'b00, 0, 0, 1, "R6");
    tick(2'b00, 2'b00, 0, 0, 0, "R9");
    check(expQ.size() == 0, "R9", expQ.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule